// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Pointer Reset Source Selection

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words enter on the write clock and leave on the read clock. Each pointer crosses into the other domain as a Gray-coded value, so full is decided on the write side and empty on the read side. The read port is show-ahead: while empty is low, `rd_data` already shows the oldest stored word, and a high `rd_en` removes that word at the next read-clock edge.

The two pointers take their resets separately. A 2-bit parameter for each side chooses what clears that side's pointer. The choices are the side's own reset input, the other side's reset input used raw, the own reset or the other reset brought in through a synchronizer, or only the synchronized other reset. The depth of each synchronizer is its own parameter. The read pointer can therefore be sent back to the start while the write pointer stays put, and the stored words can then be read out a second time without writing them again. Storage is an inferred register array with 2**`ADDR_W` words, where `ADDR_W` is at least 2. Reset inputs are active low.

Top module: `dcfifo_rstsel`

## Requirements
- R1: Once both pointers have been cleared and the resets released and settled, `empty` reads 1 and `full` reads 0.
- R2: Words leave in the order they were written, across unrelated clock ratios. `rd_data` shows the oldest word whenever `empty` is 0.
- R3: `full` is 1 whenever 2**`ADDR_W` words are stored. A write attempted while `full` is 1 stores nothing and does not move the write pointer.
- R4: `empty` is 1 whenever no word is stored. A read attempted while `empty` is 1 does not move the read pointer.
- R5: Source code 2'b00 clears a pointer only from its own side's reset input. Asserting the other side's reset alone leaves that pointer unchanged.
- R6: Source code 2'b01 clears a pointer from the other side's reset input taken without a synchronizer. That input must already be synchronous to this side's clock, and this side's own reset input is ignored.
- R7: Source code 2'b10 is the default for both sides. It clears a pointer from either its own reset input or the other side's reset after the synchronizer, so asserting either reset alone clears both pointers.
- R8: Source code 2'b11 clears a pointer only from the synchronized reset of the other side. This side's own reset input is ignored.
- R9: When only the read pointer is cleared, the words already written are presented again in the same order with no new writes, and afterwards `empty` returns to 1.
- R10: A reset that clears the pointers while words are stored also updates the flags. Once settled, `empty` is 1 and `full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side reset request, active low |
| wr_en | input | 1 | Store `wr_data` at this edge unless full |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry, as seen from the write side |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side reset request, active low |
| rd_en | input | 1 | Remove the presented word at this edge unless empty |
| rd_data | output | DATA_W | Oldest stored word (show-ahead) |
| empty | output | 1 | No stored word, as seen from the read side |

## Verification
A pointer cleared by the wrong source shows up at the ports within a few cycles of the slower clock once the reset is released. If the read pointer is left unmoved, a replay attempt finds `empty` high at once. If the write pointer is cleared when it should not be, the read side stops presenting data. A pointer that steps wrongly or skips shows on `rd_data` at the very next word presented, because a reference queue in the bench checks every word. A wrong full or empty decision shows as a flag that is low while the reference count is at its limit, checked on each clock edge. It also shows later as lost or repeated words.

// File: rtl/dcfifo_rstsel_pkg.sv
// Shared types for the dual-clock FIFO with selectable pointer resets.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dcfifo_rstsel_pkg;

    // Which reset clears a pointer (encoding is behaviour: parameters use it)
    typedef enum logic [1:0] {
        SRC_OWN         = 2'b00,  // own side's reset input only
        SRC_PEER_RAW    = 2'b01,  // other side's reset, used without synchronizer
        SRC_OWN_OR_PEER = 2'b10,  // own reset or synchronized other reset
        SRC_PEER_SYNC   = 2'b11   // synchronized other reset only
    } rst_src_e;

    // Smallest synchronizer chain that is accepted
    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/dcfifo_rst_select.sv
// Chooses the reset that clears one pointer.
// It carries the other side's reset level through a STAGES-deep flop chain
// into this clock domain, then picks a source according to MODE.
// Assumes: in SRC_PEER_RAW the peer reset is already synchronous to clk.
// The chain has no reset of its own, because it is the reset path.
// Assertion and release both travel through it.
module dcfifo_rst_select
    import dcfifo_rstsel_pkg::*;
#(
    parameter rst_src_e MODE   = SRC_OWN_OR_PEER,
    parameter int       STAGES = 2
) (
    input  logic clk,
    input  logic own_rst_n,
    input  logic peer_rst_n,
    output logic ptr_rst_n
);
    localparam int N = (STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : STAGES;

    logic [N-1:0] chain;
    logic         peer_sync_n;

    // Shift the other side's reset level into this clock domain
    always_ff @(posedge clk) begin
        chain <= {chain[N-2:0], peer_rst_n};
    end

    assign peer_sync_n = chain[N-1];

    // Pick the pointer reset according to the configured source
    always_comb begin
        ptr_rst_n = peer_sync_n;
        case (MODE)
            SRC_OWN:         ptr_rst_n = own_rst_n;
            SRC_PEER_RAW:    ptr_rst_n = peer_rst_n;
            SRC_OWN_OR_PEER: ptr_rst_n = own_rst_n & peer_sync_n;
            SRC_PEER_SYNC:   ptr_rst_n = peer_sync_n;
            default:         ptr_rst_n = peer_sync_n;
        endcase
    end

endmodule

// File: rtl/dcfifo_gray_sync.sv
// Two-flop synchronizer for a Gray-coded pointer that comes from the other
// clock domain. Assumes the source changes by at most one bit per source
// edge, except while its own pointer is being reset.
// It is cleared with the receiving side's pointer reset.
module dcfifo_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Sample the remote pointer twice before it is used
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/dcfifo_wr_ctrl.sv
// Write-side pointer and full flag. It keeps a binary pointer with one wrap
// bit and publishes its Gray form. Full means the synchronized read pointer
// equals this pointer with the top two Gray bits inverted.
// Assumes ADDR_W >= 2 and rst_n already chosen by dcfifo_rst_select.
module dcfifo_wr_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full,
    output logic              wr_fire
);
    localparam int PW = ADDR_W + 1;

    logic [ADDR_W:0] wbin;
    logic [ADDR_W:0] wbin_nxt;
    logic [ADDR_W:0] full_pat;

    assign full_pat = {~rgray_sync[ADDR_W:ADDR_W-1], rgray_sync[ADDR_W-2:0]};
    assign full     = (wgray == full_pat);
    assign wr_fire  = wr_en & ~full;
    assign wbin_nxt = wbin + PW'(wr_fire);
    assign waddr    = wbin[ADDR_W-1:0];

    // Advance the write pointer and its Gray copy on every accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && full) |=> $stable(wbin)) else $error("write accepted while full"); // R3
    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !full) |=> (wbin == $past(wbin) + PW'(1))) else $error("write pointer did not step by one"); // R2

endmodule

// File: rtl/dcfifo_rd_ctrl.sv
// Read-side pointer and empty flag. It keeps a binary pointer with one wrap
// bit and publishes its Gray form. Empty means the synchronized write
// pointer equals this pointer.
// Assumes rst_n already chosen by dcfifo_rst_select.
module dcfifo_rd_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_sync,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              empty
);
    localparam int PW = ADDR_W + 1;

    logic [ADDR_W:0] rbin;
    logic [ADDR_W:0] rbin_nxt;
    logic            rd_fire;

    assign empty    = (rgray == wgray_sync);
    assign rd_fire  = rd_en & ~empty;
    assign rbin_nxt = rbin + PW'(rd_fire);
    assign raddr    = rbin[ADDR_W-1:0];

    // Advance the read pointer and its Gray copy on every accepted read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && empty) |=> $stable(rbin)) else $error("read accepted while empty"); // R4
    AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !empty) |=> (rbin == $past(rbin) + PW'(1))) else $error("read pointer did not step by one"); // R2

endmodule

// File: rtl/dcfifo_rstsel.sv
// Dual-clock FIFO top. Each pointer takes its reset from a source chosen by
// WR_RST_MODE / RD_RST_MODE (see dcfifo_rstsel_pkg::rst_src_e). Pointers
// cross domains in Gray code. Storage is an inferred array with a show-ahead
// read port.
// Assumes ADDR_W >= 2 and sync stage counts >= 2.
module dcfifo_rstsel
    import dcfifo_rstsel_pkg::*;
#(
    parameter int       DATA_W         = 8,
    parameter int       ADDR_W         = 4,
    parameter rst_src_e WR_RST_MODE    = SRC_OWN_OR_PEER,
    parameter rst_src_e RD_RST_MODE    = SRC_OWN_OR_PEER,
    parameter int       WR_SYNC_STAGES = 2,
    parameter int       RD_SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              wptr_rst_n;
    logic              rptr_rst_n;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [ADDR_W:0]   wgray;
    logic [ADDR_W:0]   rgray;
    logic [ADDR_W:0]   wgray_rd;
    logic [ADDR_W:0]   rgray_wr;
    logic              wr_fire;
    logic [DATA_W-1:0] mem [DEPTH];

    dcfifo_rst_select #(.MODE(WR_RST_MODE), .STAGES(WR_SYNC_STAGES)) u_wr_rsel (
        .clk(wr_clk), .own_rst_n(wr_rst_n), .peer_rst_n(rd_rst_n), .ptr_rst_n(wptr_rst_n)
    );

    dcfifo_rst_select #(.MODE(RD_RST_MODE), .STAGES(RD_SYNC_STAGES)) u_rd_rsel (
        .clk(rd_clk), .own_rst_n(rd_rst_n), .peer_rst_n(wr_rst_n), .ptr_rst_n(rptr_rst_n)
    );

    dcfifo_gray_sync #(.W(ADDR_W + 1)) u_r2w (
        .clk(wr_clk), .rst_n(wptr_rst_n), .d(rgray), .q(rgray_wr)
    );

    dcfifo_gray_sync #(.W(ADDR_W + 1)) u_w2r (
        .clk(rd_clk), .rst_n(rptr_rst_n), .d(wgray), .q(wgray_rd)
    );

    dcfifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(wptr_rst_n), .wr_en(wr_en), .rgray_sync(rgray_wr),
        .waddr(waddr), .wgray(wgray), .full(full), .wr_fire(wr_fire)
    );

    dcfifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst_n(rptr_rst_n), .rd_en(rd_en), .wgray_sync(wgray_rd),
        .raddr(raddr), .rgray(rgray), .empty(empty)
    );

    // Store an accepted word; storage itself is never cleared
    always_ff @(posedge wr_clk) begin
        if (wr_fire) begin
            mem[waddr] <= wr_data;
        end
    end

    assign rd_data = mem[raddr];

endmodule

// File: tb/dcfifo_rstsel_tb_top.sv
`timescale 1ns/1ps
// Bench: four units, one per source-code pairing (own/own, raw/sync,
// either/either, sync/raw), on 50 MHz and 76.9 MHz clocks in both roles.
// A behavioural reference (array + absolute counters) is checked per clock.
module dcfifo_rstsel_tb_top;
    import dcfifo_rstsel_pkg::*;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    int   n_chk  = 0;
    int   n_fail = 0;
    int   n_done = 0;

    always #10.0 clk_a = ~clk_a;
    always #6.5  clk_b = ~clk_b;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    for (genvar g = 0; g < 4; g++) begin : g_u
        localparam rst_src_e WM = rst_src_e'(g == 0 ? 2'b00 : g == 1 ? 2'b01 : g == 2 ? 2'b10 : 2'b11);
        localparam rst_src_e RM = rst_src_e'(g == 0 ? 2'b00 : g == 1 ? 2'b11 : g == 2 ? 2'b10 : 2'b01);
        localparam string MT = (g == 0) ? "R5" : (g == 1) ? "R6/R8" : (g == 2) ? "R7" : "R8/R6";

        logic       wclk, rclk, wrst_clk, rrst_clk;
        logic       wr_rst_n = 1'b0;
        logic       rd_rst_n = 1'b0;
        logic       wr_en    = 1'b0;
        logic       rd_en    = 1'b0;
        logic [7:0] wr_data  = '0;
        logic [7:0] rd_data;
        logic       full, empty;
        logic [7:0] mdl [16];
        int         w = 0;
        int         r = 0;
        bit         live = 1'b0;

        assign wclk     = (g < 2) ? clk_a : clk_b;
        assign rclk     = (g < 2) ? clk_b : clk_a;
        assign wrst_clk = (g == 3) ? rclk : wclk;   // raw into read side
        assign rrst_clk = (g == 1) ? wclk : rclk;   // raw into write side

        dcfifo_rstsel #(
            .DATA_W(8), .ADDR_W(4), .WR_RST_MODE(WM), .RD_RST_MODE(RM),
            .WR_SYNC_STAGES(2 + g % 2), .RD_SYNC_STAGES(3 - g % 2)
        ) dut_i (
            .wr_clk(wclk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
            .rd_clk(rclk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
        );

        // Per-clock reference comparison of the flags
        always @(negedge wclk) begin
            if (live && (w - r) == 16) chk(full == 1'b1, $sformatf("u%0d R3 full at limit", g), full, 1);
        end
        always @(negedge rclk) begin
            if (live && w == r) chk(empty == 1'b1, $sformatf("u%0d R4 empty with none stored", g), empty, 1);
        end

        task automatic settle();
            repeat (12) @(negedge clk_a);
        endtask

        task automatic reset_both();
            live = 1'b0;
            @(negedge wrst_clk) wr_rst_n = 1'b0;
            @(negedge rrst_clk) rd_rst_n = 1'b0;
            settle();
            @(negedge wrst_clk) wr_rst_n = 1'b1;
            @(negedge rrst_clk) rd_rst_n = 1'b1;
            settle();
            w = 0;
            r = 0;
        endtask

        task automatic pulse(input bit on_wr);
            live = 1'b0;
            if (on_wr) begin
                @(negedge wrst_clk) wr_rst_n = 1'b0;
                settle();
                @(negedge wrst_clk) wr_rst_n = 1'b1;
            end else begin
                @(negedge rrst_clk) rd_rst_n = 1'b0;
                settle();
                @(negedge rrst_clk) rd_rst_n = 1'b1;
            end
            settle();
        endtask

        task automatic push(input int n, input int seed);
            for (int i = 0; i < n; i++) begin
                @(negedge wclk);
                if ((i * 7 + seed) % 5 == 0) begin
                    wr_en = 1'b0;
                    @(negedge wclk);
                end
                while (full) begin
                    wr_en = 1'b1;          // attempted write while full (R3)
                    @(negedge wclk);
                end
                wr_en   = 1'b1;
                wr_data = 8'(seed * 29 + i * 37 + 5);
                @(posedge wclk);
                mdl[w % 16] = wr_data;
                w++;
            end
            @(negedge wclk) wr_en = 1'b0;
        endtask

        task automatic pop(input int n, input int seed);
            for (int i = 0; i < n; i++) begin
                @(negedge rclk);
                if ((i * 3 + seed) % 4 == 0) begin
                    rd_en = 1'b0;
                    @(negedge rclk);
                end
                while (empty) begin
                    rd_en = 1'b1;          // attempted read while empty (R4)
                    @(negedge rclk);
                end
                chk(rd_data == mdl[r % 16], $sformatf("u%0d R2 read order", g), rd_data, mdl[r % 16]);
                rd_en = 1'b1;
                @(posedge rclk);
                r++;
            end
            @(negedge rclk) rd_en = 1'b0;
        endtask

        task automatic replay(input bit on_wr);
            push(10, g + 3);
            pop(10, g);
            settle();
            pulse(on_wr);
            r = 0;
            live = 1'b1;
            @(negedge rclk);
            chk(empty == 1'b0, $sformatf("u%0d R9 %s only read pointer cleared", g, MT), empty, 0);
            if (!empty) pop(10, g + 1);
            settle();
            @(negedge rclk);
            chk(empty == 1'b1, $sformatf("u%0d R9 empty after replay", g), empty, 1);
        endtask

        task automatic single_reset(input bit on_wr);
            push(5, g + 9);
            settle();
            pulse(on_wr);
            w = 0;
            r = 0;
            live = 1'b1;
            @(negedge rclk);
            chk(empty == 1'b1, $sformatf("u%0d R7 R10 empty after one reset", g), empty, 1);
            @(negedge wclk);
            chk(full == 1'b0, $sformatf("u%0d R10 full clear after reset", g), full, 0);
            fork
                push(20, g + 11);
                pop(20, g + 2);
            join
        endtask

        initial begin
            reset_both();
            @(negedge rclk);
            chk(empty == 1'b1, $sformatf("u%0d R1 empty after reset", g), empty, 1);
            @(negedge wclk);
            chk(full == 1'b0, $sformatf("u%0d R1 full after reset", g), full, 0);
            live = 1'b1;
            push(16, g);
            repeat (8) @(negedge wclk);
            chk(full == 1'b1, $sformatf("u%0d R3 full after 16 writes", g), full, 1);
            fork
                push(40, g + 1);
                pop(56, g);
            join
            settle();
            @(negedge rclk);
            chk(empty == 1'b1, $sformatf("u%0d R4 empty after drain", g), empty, 1);
            reset_both();
            live = 1'b1;
            case (g)
                0:       replay(1'b0);   // R5: own-only sources, read reset alone
                1:       replay(1'b1);   // R6 write ignores own reset, R8 read syncs it
                3:       replay(1'b1);   // R8 write ignores own reset, R6 read raw
                default: begin           // R7: either reset clears both pointers
                    single_reset(1'b1);
                    single_reset(1'b0);
                end
            endcase
            n_done++;
        end
    end

    initial begin
        fork
            wait (n_done == 4);
            begin
                #2_000_000;
                n_fail++;
                n_chk++;
                $display("FAIL watchdog expired: actual=%0d units done expected=%0d", n_done, 4);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule